// File: doc/BRIEF.md
# Inline ECC Protected-Region Matcher

This block decides, for each memory access address, whether the access lies inside a region where inline error correction is checked. It holds three programmable regions. Each region has a lower bound and an upper bound. Both bounds count 64 KB granules of the access offset from a fixed memory base. An access is covered by a region when its granule lies between the two bounds, with both ends included. The block reports whether any region covers the access. It also reports the lowest-numbered covering region and a "protected" flag, which a global enable bit gates.

Software reaches the bounds and the enable bit through a small register port with a one-cycle read. To take a region out of checking for a while, software writes its bounds in swapped order, so the lower bound exceeds the upper one. Writing the original values back puts the region into service again. A lookup is presented with a valid strobe, and its result appears on registered outputs one clock later.

Top module: `ecc_region_matcher`

## Requirements
- R1: After reset the enable bit is 1. Region 0 has lower bound 0x000000 and upper bound 0xFFFFFF, so it covers the full space. Regions 1 and 2 have lower bound 0xFFFFFF and upper bound 0x000000, so they are empty.
- R2: Register map on the 8-bit byte address. The control register sits at 0x00, with the enable in bit 0. Region n has its lower bound at 0x10+8n and its upper bound at 0x14+8n. Each bound is a 24-bit field in bits 23:0, and bits 31:24 read as zero. Read data appears on cfg_rdata one clock after a read is requested.
- R3: The granule of an access is (lk_addr − MEM_BASE) >> 16. A region covers the access when lower ≤ granule ≤ upper, with both ends included.
- R4: A region whose lower bound is greater than its upper bound covers no address.
- R5: When several regions cover an access, res_region reports the lowest-numbered one. When no region covers it, res_hit is 0 and res_region is 0.
- R6: res_prot equals res_hit ANDed with the enable bit. res_hit does not depend on the enable bit.
- R7: An address below MEM_BASE is never covered.
- R8: A lookup presented with lk_valid gives res_valid high exactly one clock later, and res_valid is low otherwise. A lookup uses the register values from before any register write in the same cycle.
- R9: A write to an address outside the map changes no register. A read from such an address returns 0.
- R10: Writing a region's bounds in swapped order removes it from matching. Writing the original order back restores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Register access request |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid one clock after the read request |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 40 | Access address to classify |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Some region covers the address |
| res_prot | output | 1 | Covered and checking enabled |
| res_region | output | 2 | Lowest covering region index |

## Verification
A register write and a lookup can happen in the same clock. This matters most when software swaps or restores a region's bounds while accesses are still being classified. The bench provokes the case by driving a bound write and a lookup on the same edge. It expects that lookup to be judged against the bounds from before the write, and a lookup on the next clock to be judged against the new bounds. The scoreboard predicts each result from a shadow copy of the registers, and it updates that copy only after the cycle of the write.

// File: rtl/ecc_rgn_pkg.sv
// Package: constants shared by the region matcher modules.
// Assumes byte-addressed registers of 32 bits on an 8-bit address.
package ecc_rgn_pkg;
    localparam int unsigned CFG_AW     = 8;
    localparam int unsigned CFG_DW     = 32;
    localparam int unsigned CTRL_OFS   = 8'h00;
    localparam int unsigned RGN_OFS    = 8'h10;
    localparam int unsigned RGN_STRIDE = 8;
    localparam int unsigned HI_DELTA   = 4;
    localparam int unsigned GRAN_SHIFT = 16;
endpackage

// File: rtl/ecc_rgn_regs.sv
// Register file: enable bit plus a lower/upper bound pair per region.
// Assumes: writes take effect on the clock edge; reads are registered.
// Addresses outside the map are ignored on write and read as zero.
module ecc_rgn_regs
    import ecc_rgn_pkg::*;
#(
    parameter int unsigned NREG   = 3,
    parameter int unsigned GRAN_W = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_en,
    input  logic                        cfg_we,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [CFG_DW-1:0]           cfg_wdata,
    output logic [CFG_DW-1:0]           cfg_rdata,
    output logic                        ecc_on,
    output logic [NREG-1:0][GRAN_W-1:0] lo_q,
    output logic [NREG-1:0][GRAN_W-1:0] hi_q
);
    localparam logic [CFG_AW-1:0] CTRL_A = CFG_AW'(CTRL_OFS);

    logic            wr;
    logic            ctrl_sel;
    logic [NREG-1:0] lo_sel;
    logic [NREG-1:0] hi_sel;
    logic            mapped;
    logic [CFG_DW-1:0] rd_mux;

    assign wr       = cfg_en && cfg_we;
    assign ctrl_sel = (cfg_addr == CTRL_A);
    assign mapped   = ctrl_sel || (|lo_sel) || (|hi_sel);

    // Enable bit storage; resets with checking on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ecc_on <= 1'b1;
        else if (wr && ctrl_sel)
            ecc_on <= cfg_wdata[0];
    end

    for (genvar i = 0; i < NREG; i++) begin : g_rgn
        localparam logic [CFG_AW-1:0] LO_A = CFG_AW'(RGN_OFS + i * RGN_STRIDE);
        localparam logic [CFG_AW-1:0] HI_A = CFG_AW'(RGN_OFS + i * RGN_STRIDE + HI_DELTA);
        localparam logic [GRAN_W-1:0] LO_RST = (i == 0) ? '0 : '1;
        localparam logic [GRAN_W-1:0] HI_RST = (i == 0) ? '1 : '0;

        assign lo_sel[i] = (cfg_addr == LO_A);
        assign hi_sel[i] = (cfg_addr == HI_A);

        // Lower bound of region i; region 0 resets to the whole space.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lo_q[i] <= LO_RST;
            else if (wr && lo_sel[i])
                lo_q[i] <= cfg_wdata[GRAN_W-1:0];
        end

        // Upper bound of region i; other regions reset to empty.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hi_q[i] <= HI_RST;
            else if (wr && hi_sel[i])
                hi_q[i] <= cfg_wdata[GRAN_W-1:0];
        end
    end

    // Read multiplexer over all mapped registers.
    always_comb begin
        rd_mux = '0;
        if (ctrl_sel)
            rd_mux[0] = ecc_on;
        for (int i = 0; i < NREG; i++) begin
            if (lo_sel[i]) rd_mux[GRAN_W-1:0] = lo_q[i];
            if (hi_sel[i]) rd_mux[GRAN_W-1:0] = hi_q[i];
        end
    end

    // Registered read data, updated on read requests only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_rdata <= '0;
        else if (cfg_en && !cfg_we)
            cfg_rdata <= rd_mux;
    end

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mapped) |=> ($stable(lo_q) && $stable(hi_q) && $stable(ecc_on)));
endmodule

// File: rtl/ecc_rgn_cmp.sv
// Bound comparator for one region: inclusive lower/upper test on a granule.
// Assumes: a region with lower > upper naturally matches nothing.
module ecc_rgn_cmp #(
    parameter int unsigned GRAN_W = 24
) (
    input  logic [GRAN_W-1:0] gran,
    input  logic              in_space,
    input  logic [GRAN_W-1:0] lo,
    input  logic [GRAN_W-1:0] hi,
    output logic              match
);
    // Inclusive window test, qualified by the address being above the base.
    always_comb match = in_space && (gran >= lo) && (gran <= hi);
endmodule

// File: rtl/ecc_rgn_prio.sv
// Fixed-priority picker: the lowest-numbered request wins.
// Assumes N >= 2; outputs index 0 when nothing is requested.
module ecc_rgn_prio #(
    parameter int unsigned N     = 3,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan from the top down so the lowest request is the last to win.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx = IDX_W'(i);
            end
        end
        any = |req;
    end

    // R5
    always_comb begin
        grant_onehot_chk: assert ($onehot0(grant));
    end

    // R5
    always_comb begin
        grant_in_req_chk: assert ((grant & ~req) == '0);
    end
endmodule

// File: rtl/ecc_region_matcher.sv
// Top: classifies access addresses against the programmable ECC regions.
// Assumes MEM_BASE is granule aligned; the result is registered, one clock
// after lk_valid, and uses the register state from before a same-cycle write.
module ecc_region_matcher
    import ecc_rgn_pkg::*;
#(
    parameter int unsigned          NREG     = 3,
    parameter int unsigned          ADDR_W   = 40,
    parameter logic [ADDR_W-1:0]    MEM_BASE = 40'h80_0000_0000,
    localparam int unsigned         IDX_W    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_prot,
    output logic [IDX_W-1:0]  res_region
);
    localparam int unsigned GRAN_W = ADDR_W - GRAN_SHIFT;

    logic                        ecc_on;
    logic [NREG-1:0][GRAN_W-1:0] lo_q;
    logic [NREG-1:0][GRAN_W-1:0] hi_q;
    logic [ADDR_W-1:0]           offset;
    logic                        in_space;
    logic [GRAN_W-1:0]           gran;
    logic [NREG-1:0]             match;
    logic [NREG-1:0]             grant;
    logic [IDX_W-1:0]            win_idx;
    logic                        any_hit;

    ecc_rgn_regs #(.NREG(NREG), .GRAN_W(GRAN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ecc_on    (ecc_on),
        .lo_q      (lo_q),
        .hi_q      (hi_q)
    );

    // Offset from the memory base and its granule number.
    always_comb begin
        offset   = lk_addr - MEM_BASE;
        in_space = (lk_addr >= MEM_BASE);
        gran     = offset[ADDR_W-1:GRAN_SHIFT];
    end

    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        ecc_rgn_cmp #(.GRAN_W(GRAN_W)) u_cmp (
            .gran     (gran),
            .in_space (in_space),
            .lo       (lo_q[i]),
            .hi       (hi_q[i]),
            .match    (match[i])
        );
    end

    ecc_rgn_prio #(.N(NREG), .IDX_W(IDX_W)) u_prio (
        .req   (match),
        .grant (grant),
        .idx   (win_idx),
        .any   (any_hit)
    );

    // Result register: capture the classification of each lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_prot   <= 1'b0;
            res_region <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_hit    <= any_hit;
                res_prot   <= any_hit && ecc_on;
                res_region <= win_idx;
            end
        end
    end

    // R8
    res_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R8
    res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    // R6
    prot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_prot |-> res_hit);

    // R5
    miss_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_region == '0));
endmodule

// File: tb/sim_ecc_region_matcher.sv
module sim_ecc_region_matcher;
    localparam logic [39:0] BASE = 40'h80_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [39:0] lk_addr = '0;
    logic        res_valid, res_hit, res_prot;
    logic [1:0]  res_region;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Shadow of the register state, maintained from the requirements.
    logic [23:0] sh_lo [3];
    logic [23:0] sh_hi [3];
    logic        sh_on;

    typedef struct { logic hit; logic prot; logic [1:0] rgn; string tag; } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    ecc_region_matcher u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
        .res_hit(res_hit), .res_prot(res_prot), .res_region(res_region)
    );

    task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] ga(input logic [23:0] g, input logic [15:0] low);
        return BASE + {g, low};
    endfunction

    function automatic exp_t predict(input logic [39:0] a, input string tag);
        exp_t e;
        logic [23:0] g;
        e.hit = 1'b0; e.rgn = 2'd0; e.tag = tag;
        g = 24'((a - BASE) >> 16);
        if (a >= BASE) begin
            for (int i = 2; i >= 0; i--)
                if (sh_lo[i] <= g && g <= sh_hi[i]) begin
                    e.hit = 1'b1; e.rgn = 2'(i);
                end
        end
        e.prot = e.hit & sh_on;
        return e;
    endfunction

    // Shadow update for a completed write (R2 map, R9 unmapped ignored).
    task automatic shadow_wr(input logic [7:0] a, input logic [31:0] d);
        if (a == 8'h00) sh_on = d[0];
        for (int i = 0; i < 3; i++) begin
            if (a == 8'(8'h10 + 8 * i)) sh_lo[i] = d[23:0];
            if (a == 8'(8'h14 + 8 * i)) sh_hi[i] = d[23:0];
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0;
        shadow_wr(a, d);
    endtask

    task automatic reg_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b0; cfg_addr = a;
        @(negedge clk);
        cfg_en = 1'b0;
        check(cfg_rdata === exp, tag, 40'(cfg_rdata), 40'(exp));
    endtask

    // Driver: present one lookup and push its predicted result.
    task automatic lookup(input logic [39:0] a, input string tag);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        sb.push_back(predict(a, tag));
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // Write and lookup on the same edge: lookup sees the old bounds (R8).
    task automatic wr_with_lookup(input logic [7:0] ra, input logic [31:0] d,
                                  input logic [39:0] a, input string tag);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = ra; cfg_wdata = d;
        lk_valid = 1'b1; lk_addr = a;
        sb.push_back(predict(a, tag));
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0; lk_valid = 1'b0;
        shadow_wr(ra, d);
    endtask

    // Monitor: compare each produced result with the queue head.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected res_valid", 40'd1, 40'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({res_hit, res_prot, res_region} === {e.hit, e.prot, e.rgn},
                      e.tag, 40'({res_hit, res_prot, res_region}),
                      40'({e.hit, e.prot, e.rgn}));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        sh_on = 1'b1;
        sh_lo[0] = 24'h000000; sh_hi[0] = 24'hFFFFFF;
        for (int i = 1; i < 3; i++) begin sh_lo[i] = 24'hFFFFFF; sh_hi[i] = 24'h000000; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid === 1'b0, "R8 idle after reset", 40'(res_valid), 40'd0);

        // R1 / R2 reset values through the register map
        reg_rd(8'h00, 32'h1, "R1 ctrl reset");
        reg_rd(8'h10, 32'h0, "R1 r0 lower reset");
        reg_rd(8'h14, 32'h00FFFFFF, "R1 r0 upper reset");
        reg_rd(8'h18, 32'h00FFFFFF, "R1 r1 lower reset");
        reg_rd(8'h1C, 32'h0, "R1 r1 upper reset");
        reg_rd(8'h20, 32'h00FFFFFF, "R1 r2 lower reset");
        reg_rd(8'h24, 32'h0, "R1 r2 upper reset");

        // R3 / R7 full-space region 0
        lookup(BASE, "R3 base addr in r0");
        lookup(40'hFF_FFFF_FFFF, "R3 top addr in r0");
        lookup(BASE - 40'd1, "R7 below base");
        lookup(40'h00_0000_1000, "R7 far below base");

        // R10: swap region 0 bounds to turn it off
        reg_wr(8'h14, 32'h000000);
        reg_wr(8'h10, 32'hFFFFFF);
        lookup(ga(24'h000100, 16'h1234), "R10 r0 swapped no hit");

        // R2 upper bits read as zero; R3 inclusive window on region 1
        reg_wr(8'h18, 32'hAB000010);
        reg_rd(8'h18, 32'h00000010, "R2 bound upper bits zero");
        reg_wr(8'h1C, 32'h0000001F);
        lookup(ga(24'h10, 16'h0000), "R3 r1 lower edge");
        lookup(ga(24'h1F, 16'hFFFF), "R3 r1 upper edge");
        lookup(ga(24'h0F, 16'hFFFF), "R3 r1 just below");
        lookup(ga(24'h20, 16'h0000), "R3 r1 just above");

        // R5 overlap: region 2 overlaps region 1
        reg_wr(8'h20, 32'h18);
        reg_wr(8'h24, 32'h30);
        lookup(ga(24'h18, 16'h0), "R5 overlap lowest wins");
        lookup(ga(24'h25, 16'h0), "R5 only r2");

        // R4 inverted bounds on region 2
        reg_wr(8'h20, 32'h40);
        reg_wr(8'h24, 32'h35);
        lookup(ga(24'h38, 16'h0), "R4 inverted matches nothing");
        lookup(ga(24'h35, 16'h0), "R4 inverted at upper");

        // R6 enable off: hit stays, prot drops
        reg_wr(8'h00, 32'h0);
        lookup(ga(24'h12, 16'h0), "R6 enable off");
        reg_rd(8'h00, 32'h0, "R6 ctrl readback");
        reg_wr(8'h00, 32'h1);
        lookup(ga(24'h12, 16'h0), "R6 enable on");

        // R9 unmapped writes ignored, reads zero
        reg_wr(8'h40, 32'hFFFFFFFF);
        reg_wr(8'h0C, 32'h0);
        reg_wr(8'h28, 32'h0);
        reg_rd(8'h40, 32'h0, "R9 unmapped reads zero");
        reg_rd(8'h1C, 32'h1F, "R9 r1 upper unchanged");
        reg_rd(8'h00, 32'h1, "R9 ctrl unchanged");
        lookup(ga(24'h1F, 16'h0), "R9 lookup unchanged");

        // R8 same-cycle write and lookup, then the new bounds apply
        wr_with_lookup(8'h1C, 32'h0F, ga(24'h15, 16'h0), "R8 same-cycle old bounds");
        lookup(ga(24'h15, 16'h0), "R8 next cycle new bounds");

        // R10 restore region 0 original order
        reg_wr(8'h10, 32'h000000);
        reg_wr(8'h14, 32'hFFFFFF);
        lookup(ga(24'h000100, 16'h1234), "R10 r0 restored");
        lookup(ga(24'h12, 16'h0), "R5 r0 beats r1 after restore");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R8 all results seen", 40'(sb.size()), 40'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule